// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a base-frequency timing pulse into three timing outputs for a real-time clock: a one-cycle periodic interrupt pulse, an optional square wave, and a once-per-second tick that advances the time-of-day counter. The input `base_tick_i` is a clock enable that pulses at the chosen oscillator frequency, which is one of 4.194304 MHz, 1.048576 MHz or 32.768 kHz. A 3-bit time-base code tells the block which frequency it has and how far to divide it down. A fixed prescaler first brings every base down to a common 32768 Hz tick. A 15-bit chain then divides that tick further.

A 4-bit rate code picks one power-of-two tap of the chain for the periodic pulse and the square wave. The two lowest nonzero codes map to different taps depending on the time base. Two time-base codes park the whole divider in a cleared state. When the divider leaves that state, counting restarts from zero, so the first second tick falls exactly one second later.

Top module: `rtc_rate_gen`

## Requirements
- R1: Rate code 0 produces no periodic pulse, and the square wave stays low even when it is enabled.
- R2: Rate codes 3 to 15 give one periodic pulse every 2^(code-1) prescaled ticks: code 3 gives one every 4 ticks (8192 Hz) and code 15 gives one every 16384 ticks (2 Hz).
- R3: When the time-base code is 010 (or any of 011, 100, 101), rate code 1 gives a pulse every 128 prescaled ticks (256 Hz) and rate code 2 gives one every 256 ticks (128 Hz).
- R4: When the time-base code is 000 or 001, rate code 1 gives a pulse on every prescaled tick (32768 Hz) and rate code 2 gives one every 2 ticks (16384 Hz).
- R5: The prescaler makes one 32768 Hz tick from every 128 base pulses with time-base code 000, from every 32 base pulses with code 001, and from every base pulse with codes 010 to 101.
- R6: Time-base codes 110 and 111 clear and hold the prescaler and the chain. While held, the periodic output, the square wave and the second tick all stay low.
- R7: After the hold is released, the first second tick follows the 32768th prescaled tick. Later second ticks follow at intervals of 32768 prescaled ticks.
- R8: Each periodic pulse and each second tick is high for exactly one clock cycle. Each appears in the cycle after the edge that took the final base pulse.
- R9: The square-wave enable gates the square wave, which is low whenever the enable is clear. When enabled, the wave starts low and toggles every half period (2^(e-1) prescaled ticks, where the pulse period is 2^e). At the one-tick period it toggles on every tick.
- R10: A new rate code takes effect at the next boundary of the new tap, and the chain count is not disturbed. The square wave changes level only one cycle after an edge that took a base pulse, or after it has been disabled.
- R11: Without a base pulse nothing advances: the periodic pulse and second tick follow the count of base pulses, not the count of clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick_i | input | 1 | One-cycle pulse at the oscillator base frequency |
| div_sel_i | input | 3 | Time-base code (000 4 MHz, 001 1 MHz, 010 32 kHz, 110/111 hold) |
| rate_sel_i | input | 4 | Periodic rate code |
| sqw_en_i | input | 1 | Square-wave output enable |
| periodic_o | output | 1 | One-cycle periodic interrupt pulse |
| sqw_o | output | 1 | Square wave at the selected rate |
| sec_tick_o | output | 1 | One-cycle once-per-second tick |

## Verification
The bench measures when the first pulse arrives and how many pulses fall in a window. It does this at both ends of the rate range and for the two low codes under each time base. A design that mapped codes 1 and 2 the same way for every base would be early or late by a factor of 128 in one of those runs. It also times the first second tick after a hold. A divider left counting during the hold, or not cleared by it, would give a first tick earlier than 32768. Separate runs cover a rate change mid-stream, gapped base pulses and the disabled-output cases. In these runs, counting clock cycles instead of ticks would double the pulse rate, and an ungated square wave would show up as a high level where low is required.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  localparam int unsigned CHAIN_W    = 15;
  localparam int unsigned RATE_W     = 4;
  localparam int unsigned DIV_W      = 3;
  localparam int unsigned PRE_HI_LOG = 7;
  localparam int unsigned PRE_MD_LOG = 5;
  localparam int unsigned PRE_W      = PRE_HI_LOG;
  localparam int unsigned EXP_W      = $clog2(CHAIN_W);
  localparam int unsigned LOWB_OFS   = 6;

  localparam logic [DIV_W-1:0] DIV_HI_BASE = 3'b000;
  localparam logic [DIV_W-1:0] DIV_MD_BASE = 3'b001;

  function automatic logic div_is_hold(input logic [DIV_W-1:0] code);
    return code[2] & code[1];
  endfunction

  function automatic logic div_is_low_base(input logic [DIV_W-1:0] code);
    return (code != DIV_HI_BASE) && (code != DIV_MD_BASE) && !div_is_hold(code);
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale
  import rtc_rate_pkg::*;
#(
  parameter int unsigned HI_LOG = PRE_HI_LOG,
  parameter int unsigned MD_LOG = PRE_MD_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             tick_o
);

  localparam int unsigned W = HI_LOG;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] wrap_mask;
  logic         hold;

  assign hold = div_is_hold(div_sel_i);

  always_comb begin
    unique case (div_sel_i)
      DIV_HI_BASE: wrap_mask = W'((1 << HI_LOG) - 1);
      DIV_MD_BASE: wrap_mask = W'((1 << MD_LOG) - 1);
      default:     wrap_mask = '0;
    endcase
  end

  assign tick_o = base_tick_i && !hold && ((cnt_q & wrap_mask) == wrap_mask);

  always_comb begin
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = '0;
    end else if (base_tick_i) begin
      cnt_d = (cnt_q + 1'b1) & wrap_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_rate_pkg::*;
#(
  parameter int unsigned W = CHAIN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o,
  output logic         sec_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         sec_q, sec_d;

  always_comb begin
    cnt_d = cnt_q;
    sec_d = 1'b0;
    if (hold_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
      sec_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sec_q <= sec_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sec_o = sec_q;

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
  import rtc_rate_pkg::*;
#(
  parameter int unsigned W = CHAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              low_base_i,
  input  logic [W-1:0]      cnt_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              sqw_en_i,
  output logic              pulse_o,
  output logic              sqw_o
);

  logic [EXP_W-1:0] tap_exp;
  logic [W:0]       one_ext;
  logic [W-1:0]     full_mask, half_mask;
  logic             rate_on, at_full, at_half;
  logic             pulse_q, pulse_d, sqw_q, sqw_d;

  assign one_ext = {{W{1'b0}}, 1'b1};
  assign rate_on = (rate_sel_i != '0);

  always_comb begin
    if (low_base_i && (rate_sel_i == RATE_W'(1) || rate_sel_i == RATE_W'(2))) begin
      tap_exp = EXP_W'(rate_sel_i) + EXP_W'(LOWB_OFS);
    end else begin
      tap_exp = EXP_W'(rate_sel_i) - 1'b1;
    end
  end

  always_comb begin
    full_mask = W'((one_ext << tap_exp) - 1'b1);
    if (tap_exp == '0) begin
      half_mask = '0;
    end else begin
      half_mask = W'((one_ext << (tap_exp - 1'b1)) - 1'b1);
    end
  end

  assign at_full = tick_i && ((cnt_i & full_mask) == full_mask);
  assign at_half = tick_i && ((cnt_i & half_mask) == half_mask);

  always_comb begin
    pulse_d = !hold_i && rate_on && at_full;
    if (hold_i || !sqw_en_i || !rate_on) begin
      sqw_d = 1'b0;
    end else if (at_half) begin
      sqw_d = !sqw_q;
    end else begin
      sqw_d = sqw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      sqw_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      sqw_q   <= sqw_d;
    end
  end

  assign pulse_o = pulse_q;
  assign sqw_o   = sqw_q;

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
#(
  parameter int unsigned CHAIN_BITS = CHAIN_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              sqw_en_i,
  output logic              periodic_o,
  output logic              sqw_o,
  output logic              sec_tick_o
);

  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  tick32k;
  logic                  hold;
  logic                  low_base;
  logic [CHAIN_BITS-1:0] chain_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_DEPTH-1];

  assign hold     = div_is_hold(div_sel_i);
  assign low_base = div_is_low_base(div_sel_i);

  rtc_prescale u_pre (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .base_tick_i (base_tick_i),
    .div_sel_i   (div_sel_i),
    .tick_o      (tick32k)
  );

  rtc_div_chain #(.W(CHAIN_BITS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick32k),
    .hold_i (hold),
    .cnt_o  (chain_cnt),
    .sec_o  (sec_tick_o)
  );

  rtc_tap_sel #(.W(CHAIN_BITS)) u_tap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick32k),
    .hold_i     (hold),
    .low_base_i (low_base),
    .cnt_i      (chain_cnt),
    .rate_sel_i (rate_sel_i),
    .sqw_en_i   (sqw_en_i),
    .pulse_o    (periodic_o),
    .sqw_o      (sqw_o)
  );

endmodule

// File: rtl/rtc_rate_gen_chk.sv
module rtc_rate_gen_chk
  import rtc_rate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              base_tick_i,
  input logic [DIV_W-1:0]  div_sel_i,
  input logic [RATE_W-1:0] rate_sel_i,
  input logic              sqw_en_i,
  input logic              periodic_o,
  input logic              sqw_o,
  input logic              sec_tick_o
);

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel_i == '0) |=> (!periodic_o && !sqw_o));

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_is_hold(div_sel_i) |=> (!periodic_o && !sec_tick_o && !sqw_o));

  p_sqw_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en_i |=> !sqw_o);

  p_pulse_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_o |-> $past(base_tick_i));

  p_sec_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_o |-> $past(base_tick_i));

  p_sqw_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sqw_o) |-> ($past(base_tick_i) || $past(!sqw_en_i) ||
                         $past(rate_sel_i == '0) || $past(div_is_hold(div_sel_i))));

endmodule

bind rtc_rate_gen rtc_rate_gen_chk u_rtc_rate_gen_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .base_tick_i (base_tick_i),
  .div_sel_i   (div_sel_i),
  .rate_sel_i  (rate_sel_i),
  .sqw_en_i    (sqw_en_i),
  .periodic_o  (periodic_o),
  .sqw_o       (sqw_o),
  .sec_tick_o  (sec_tick_o)
);

// File: tb/rtc_rate_gen_bench.sv
module rtc_rate_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick_i = 1'b0;
  logic [2:0] div_sel_i = 3'b110;
  logic [3:0] rate_sel_i = 4'd0;
  logic       sqw_en_i = 1'b0;
  logic       periodic_o, sqw_o, sec_tick_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_rate_gen u_rtc_rate_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick_i),
    .div_sel_i   (div_sel_i),
    .rate_sel_i  (rate_sel_i),
    .sqw_en_i    (sqw_en_i),
    .periodic_o  (periodic_o),
    .sqw_o       (sqw_o),
    .sec_tick_o  (sec_tick_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Park in hold for one edge, then apply the new setting.
  task automatic start(input logic [2:0] dv, input logic [3:0] rt, input logic en);
    div_sel_i = 3'b110;
    @(negedge clk);
    div_sel_i  = dv;
    rate_sel_i = rt;
    sqw_en_i   = en;
  endtask

  // One cycle: drive base tick for edge i, then sample at the falling edge.
  task automatic step(input int i, input bit gap);
    base_tick_i = gap ? (i % 2 == 1) : 1'b1;
    @(negedge clk);
  endtask

  task automatic window(input int n, input bit gap,
                        output int fp, output int np, output int fs, output int ns,
                        output int sq_hi);
    fp = -1; np = 0; fs = -1; ns = 0; sq_hi = 0;
    for (int i = 1; i <= n; i++) begin
      step(i, gap);
      if (periodic_o) begin
        if (fp < 0) fp = i;
        np++;
      end
      if (sec_tick_o) begin
        if (fs < 0) fs = i;
        ns++;
      end
      if (sqw_o) sq_hi++;
    end
  endtask

  task automatic t_reset();
    chk("R6 reset periodic", int'(periodic_o), 0);
    chk("R6 reset sqw", int'(sqw_o), 0);
    chk("R6 reset sec", int'(sec_tick_o), 0);
  endtask

  task automatic t_hold();
    int fp, np, fs, ns, sq;
    start(3'b110, 4'd3, 1'b1);
    window(300, 1'b0, fp, np, fs, ns, sq);
    chk("R6 hold110 pulses", np, 0);
    chk("R6 hold110 sqw high", sq, 0);
    start(3'b111, 4'd3, 1'b1);
    window(300, 1'b0, fp, np, fs, ns, sq);
    chk("R6 hold111 pulses", np, 0);
    chk("R6 hold111 sqw high", sq, 0);
  endtask

  task automatic t_fast_sqw();
    int np = 0;
    int exp_sq;
    start(3'b010, 4'd3, 1'b1);
    for (int i = 1; i <= 64; i++) begin
      step(i, 1'b0);
      exp_sq = ((i / 2) % 2 == 1) ? 1 : 0;
      if (i <= 8) chk("R9 code3 sqw level", int'(sqw_o), exp_sq);
      if (periodic_o) begin
        np++;
        if (np <= 2) chk("R2 R8 code3 pulse position", i, 4 * np);
      end
    end
    chk("R2 code3 pulses in 64", np, 16);
  endtask

  task automatic t_slow_and_sec();
    int fp, np, fs, ns, sq;
    start(3'b010, 4'd15, 1'b0);
    window(65536, 1'b0, fp, np, fs, ns, sq);
    chk("R2 code15 first pulse", fp, 16384);
    chk("R2 code15 pulse count", np, 4);
    chk("R7 first second tick", fs, 32768);
    chk("R7 R8 second tick count", ns, 2);
    chk("R9 sqw disabled high", sq, 0);
  endtask

  task automatic t_low_codes_lowbase();
    int fp, np, fs, ns, sq;
    start(3'b010, 4'd1, 1'b0);
    window(512, 1'b0, fp, np, fs, ns, sq);
    chk("R3 code1 32k first", fp, 128);
    chk("R3 code1 32k count", np, 4);
    start(3'b010, 4'd2, 1'b0);
    window(512, 1'b0, fp, np, fs, ns, sq);
    chk("R3 code2 32k first", fp, 256);
    start(3'b101, 4'd1, 1'b0);
    window(256, 1'b0, fp, np, fs, ns, sq);
    chk("R3 code1 div101 first", fp, 128);
  endtask

  task automatic t_low_codes_hibase();
    int fp, np, fs, ns, sq;
    start(3'b001, 4'd1, 1'b0);
    window(320, 1'b0, fp, np, fs, ns, sq);
    chk("R4 R5 code1 1M first", fp, 32);
    chk("R4 R5 code1 1M count", np, 10);
    start(3'b001, 4'd2, 1'b0);
    window(320, 1'b0, fp, np, fs, ns, sq);
    chk("R4 code2 1M first", fp, 64);
    start(3'b000, 4'd1, 1'b0);
    window(512, 1'b0, fp, np, fs, ns, sq);
    chk("R4 R5 code1 4M first", fp, 128);
    chk("R5 code1 4M count", np, 4);
    start(3'b000, 4'd3, 1'b0);
    window(1024, 1'b0, fp, np, fs, ns, sq);
    chk("R5 code3 4M first", fp, 512);
  endtask

  task automatic t_rate_zero();
    int fp, np, fs, ns, sq;
    start(3'b010, 4'd0, 1'b1);
    window(200, 1'b0, fp, np, fs, ns, sq);
    chk("R1 code0 pulses", np, 0);
    chk("R1 code0 sqw high", sq, 0);
  endtask

  task automatic t_sqw_fastest();
    start(3'b001, 4'd1, 1'b1);
    for (int i = 1; i <= 96; i++) begin
      step(i, 1'b0);
      if (i == 31) chk("R9 one-tick sqw before", int'(sqw_o), 0);
      if (i == 32) chk("R9 one-tick sqw first toggle", int'(sqw_o), 1);
      if (i == 64) chk("R9 one-tick sqw second toggle", int'(sqw_o), 0);
    end
  endtask

  task automatic t_gapped();
    int fp, np, fs, ns, sq;
    start(3'b010, 4'd3, 1'b0);
    window(64, 1'b1, fp, np, fs, ns, sq);
    chk("R11 gapped first pulse", fp, 7);
    chk("R11 gapped pulse count", np, 8);
  endtask

  task automatic t_rate_change();
    int np = 0;
    start(3'b010, 4'd3, 1'b1);
    for (int i = 1; i <= 32; i++) begin
      step(i, 1'b0);
      if (periodic_o) np++;
      if (i == 4) chk("R10 old rate pulse", int'(periodic_o), 1);
      if (i == 6) rate_sel_i = 4'd5;
      if (i == 7) chk("R10 sqw holds after change", int'(sqw_o), 1);
      if (i == 8) chk("R10 sqw new half boundary", int'(sqw_o), 0);
      if (i == 8) chk("R10 no old-rate pulse", int'(periodic_o), 0);
      if (i == 15) chk("R10 sqw steady", int'(sqw_o), 0);
      if (i == 16) chk("R10 new rate pulse", int'(periodic_o), 1);
    end
    chk("R10 pulses across change", np, 3);
  endtask

  initial begin
    #(64'd200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_hold();
    t_fast_sqw();
    t_slow_and_sec();
    t_low_codes_lowbase();
    t_low_codes_hibase();
    t_rate_zero();
    t_sqw_fastest();
    t_gapped();
    t_rate_change();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule